// File: doc/BRIEF.md
# Custom-Instruction Interrupt Mask Unit

This unit sits beside a processor's execute stage and carries out a small group of custom R-type instructions that control interrupts. It holds a mask register, in which a set bit disables the corresponding interrupt line, and a pending set that records rising edges on the external request lines. It also holds a bank of saved-state registers that the interrupt-entry logic fills and software reads back.

Three instructions are executed. The mask swap installs a new mask from the rs1 operand and returns the previous mask in the same operation. The wait instruction stalls the pipeline until at least one interrupt is pending, and then returns the pending bitmask. The q-register read copies one saved-state register to rd. Any other function code in the group is illegal. An illegal instruction or a bus error is routed to its own interrupt bit. If that bit is masked when the fault occurs, the unit halts instead. A halted unit stays halted until reset and completes no further instruction.

The instruction port is level-held. The core keeps `instr_valid` and the word stable until `instr_done` is seen. A claimed instruction that cannot finish yet raises `instr_stall`.

Top module: `cxirq_unit`

## Requirements
- R1: An instruction belongs to the group only when bits [6:0] are 7'b0001011, bits [14:12] (funct3) are 000 and bits [24:20] (rs2) are 00000. Any other word gives no done, no stall and no illegal pulse, and it leaves the mask unchanged.
- R2: funct7 (bits [31:25]) = 7'b0000011 is the mask swap. It completes in the cycle it is presented. `rd_val` carries the old mask, and from the next cycle the mask equals `rs1_val`.
- R3: A set mask bit disables that interrupt: `irq_unmasked` equals `irq_pending` with the masked bits cleared.
- R4: A pending bit sets in the cycle after its `irq_lines` bit goes from low to high. It stays set while the line stays high or after the line drops. It clears when the same bit of `irq_clr` is high. A rise that arrives together with a clear wins.
- R5: funct7 = 7'b0000100 with the rs1 field (bits [19:15]) equal to zero is wait. While no bit is pending it stalls. Once any bit is pending, masked or not, it completes with `rd_val` equal to the pending set.
- R6: funct7 = 7'b0000000 with rs1-field bits [19:17] zero is the q-register read. Bits [16:15] select one of four registers, and `rd_val` returns that register. A register loads `q_save_data` on a cycle where `q_save_en` is high and `q_save_idx` selects it. All registers reset to zero.
- R7: Any other funct7 in the group, a wait with a nonzero rs1 field, or a q-register read with nonzero rs1-field bits [19:17] is illegal. It completes at once with `rd_val` zero and `illegal_pulse` high for that cycle.
- R8: An illegal instruction uses interrupt bit 1 and a high `bus_err` uses interrupt bit 2. If that mask bit is clear, the pending bit sets in the next cycle. If it is set, `halted` rises in the next cycle and the pending bit stays clear.
- R9: Once `halted` is high it stays high until reset. While halted, `instr_done` never asserts, and an in-group instruction keeps `instr_stall` high.
- R10: The reset is asserted asynchronously and released after two clock edges. After reset the mask is all ones, and the pending set, `halted` and the q-registers are zero.
- R11: `instr_done` and `instr_stall` are never high together, and `rd_val` is zero whenever `instr_done` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr_valid | input | 1 | Instruction word is presented and held |
| instr_word | input | 32 | Instruction word |
| rs1_val | input | DATA_W | Value of the rs1 operand |
| irq_lines | input | NIRQ | External interrupt request lines |
| irq_clr | input | NIRQ | Per-bit clear of pending interrupts that have been serviced |
| bus_err | input | 1 | Bus error event, one cycle per event |
| q_save_en | input | 1 | Load one saved-state register |
| q_save_idx | input | QIDX_W | Saved-state register to load |
| q_save_data | input | DATA_W | Value to load |
| rd_val | output | DATA_W | Result for rd, valid with instr_done |
| instr_done | output | 1 | Instruction completes this cycle |
| instr_stall | output | 1 | Claimed instruction cannot complete yet |
| illegal_pulse | output | 1 | Illegal instruction completed this cycle |
| halted | output | 1 | Unit is halted |
| irq_pending | output | NIRQ | Pending interrupt set |
| irq_unmasked | output | NIRQ | Pending interrupts that are not masked |

## Verification
The bench builds the unit with its default values: NIRQ and DATA_W both 32, four q-registers, the illegal-instruction fault on bit 1 and the bus-error fault on bit 2. With full width, the swap readback exposes every mask bit, including the all-ones reset value. Lines such as 5, 7 and 9 can be raised away from the two fault bits, so masked and unmasked pending behaviour is seen apart from fault routing. With four registers, every index encoding of the q-register read is reachable, and nonzero high rs1-field bits are tested as illegal.

// File: rtl/cxirq_pkg.sv
package cxirq_pkg;

  localparam logic [6:0] CX_OPCODE = 7'b0001011;
  localparam logic [6:0] CX_F7_SWAP = 7'b0000011;
  localparam logic [6:0] CX_F7_WAIT = 7'b0000100;
  localparam logic [6:0] CX_F7_GETQ = 7'b0000000;

  typedef enum logic [2:0] {
    CX_OP_NONE,
    CX_OP_SWAP,
    CX_OP_WAIT,
    CX_OP_GETQ,
    CX_OP_BAD
  } cx_op_e;

endpackage

// File: rtl/cxirq_decode.sv
module cxirq_decode
  import cxirq_pkg::*;
#(
  parameter int QIDX_W = 2
) (
  input  logic [31:0]       instr_word,
  output cx_op_e            op_o,
  output logic [QIDX_W-1:0] qsel_o
);

  logic [6:0] opc;
  logic [2:0] f3;
  logic [4:0] rs2f;
  logic [4:0] rs1f;
  logic [6:0] f7;
  logic       in_group;
  logic       rs1_hi_zero;

  assign opc  = instr_word[6:0];
  assign f3   = instr_word[14:12];
  assign rs1f = instr_word[19:15];
  assign rs2f = instr_word[24:20];
  assign f7   = instr_word[31:25];

  assign in_group    = (opc == CX_OPCODE) && (f3 == 3'b000) && (rs2f == 5'b00000);
  assign rs1_hi_zero = ((rs1f >> QIDX_W) == 5'd0);
  assign qsel_o      = rs1f[QIDX_W-1:0];

  always_comb begin
    op_o = CX_OP_NONE;
    if (in_group) begin
      case (f7)
        CX_F7_SWAP: op_o = CX_OP_SWAP;
        CX_F7_WAIT: op_o = (rs1f == 5'd0) ? CX_OP_WAIT : CX_OP_BAD;
        CX_F7_GETQ: op_o = rs1_hi_zero ? CX_OP_GETQ : CX_OP_BAD;
        default:    op_o = CX_OP_BAD;
      endcase
    end
  end

endmodule

// File: rtl/cxirq_pending.sv
module cxirq_pending #(
  parameter int NIRQ = 32
) (
  input  logic            clk,
  input  logic            rst_ni,
  input  logic [NIRQ-1:0] irq_lines,
  input  logic [NIRQ-1:0] clr_i,
  input  logic [NIRQ-1:0] set_i,
  output logic [NIRQ-1:0] pending_o
);

  for (genvar i = 0; i < NIRQ; i++) begin : g_bit
    logic prev_q;
    logic pend_q;
    logic pend_d;

    always_comb begin
      pend_d = (pend_q & ~clr_i[i]) | (irq_lines[i] & ~prev_q) | set_i[i];
    end

    always_ff @(posedge clk or negedge rst_ni) begin
      if (!rst_ni) begin
        prev_q <= 1'b0;
        pend_q <= 1'b0;
      end else begin
        prev_q <= irq_lines[i];
        pend_q <= pend_d;
      end
    end

    assign pending_o[i] = pend_q;

    // R4
    pend_rise_chk: assert property (@(posedge clk) disable iff (!rst_ni)
      (irq_lines[i] && !prev_q) |=> pend_q);

    // R4
    pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_ni)
      (pend_q && !clr_i[i]) |=> pend_q);
  end

endmodule

// File: rtl/cxirq_qbank.sv
module cxirq_qbank #(
  parameter int NQ     = 4,
  parameter int DATA_W = 32,
  localparam int QIDX_W = (NQ > 1) ? $clog2(NQ) : 1
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic              save_en,
  input  logic [QIDX_W-1:0] save_idx,
  input  logic [DATA_W-1:0] save_data,
  input  logic [QIDX_W-1:0] rd_idx,
  output logic [DATA_W-1:0] rd_data
);

  logic [DATA_W-1:0] ent [NQ];

  for (genvar i = 0; i < NQ; i++) begin : g_ent
    logic              ld_en;
    logic [DATA_W-1:0] ent_q;

    assign ld_en = save_en && (save_idx == QIDX_W'(i));

    always_ff @(posedge clk or negedge rst_ni) begin
      if (!rst_ni) begin
        ent_q <= '0;
      end else if (ld_en) begin
        ent_q <= save_data;
      end
    end

    assign ent[i] = ent_q;

    // R6
    q_load_chk: assert property (@(posedge clk) disable iff (!rst_ni)
      ld_en |=> (ent_q == $past(save_data)));
  end

  always_comb begin
    rd_data = '0;
    for (int k = 0; k < NQ; k++) begin
      if (rd_idx == QIDX_W'(k)) rd_data = ent[k];
    end
  end

endmodule

// File: rtl/cxirq_unit.sv
module cxirq_unit
  import cxirq_pkg::*;
#(
  parameter int NIRQ    = 32,
  parameter int DATA_W  = 32,
  parameter int NQ      = 4,
  parameter int ILL_BIT = 1,
  parameter int BUS_BIT = 2,
  localparam int QIDX_W = (NQ > 1) ? $clog2(NQ) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              instr_valid,
  input  logic [31:0]       instr_word,
  input  logic [DATA_W-1:0] rs1_val,
  input  logic [NIRQ-1:0]   irq_lines,
  input  logic [NIRQ-1:0]   irq_clr,
  input  logic              bus_err,
  input  logic              q_save_en,
  input  logic [QIDX_W-1:0] q_save_idx,
  input  logic [DATA_W-1:0] q_save_data,
  output logic [DATA_W-1:0] rd_val,
  output logic              instr_done,
  output logic              instr_stall,
  output logic              illegal_pulse,
  output logic              halted,
  output logic [NIRQ-1:0]   irq_pending,
  output logic [NIRQ-1:0]   irq_unmasked
);

  // reset: asynchronous assert, release after two edges
  logic [1:0] rst_sync_q;
  logic       rst_ni;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ni = rst_sync_q[1];

  // decode
  cx_op_e            op;
  logic [QIDX_W-1:0] qsel;

  cxirq_decode #(.QIDX_W(QIDX_W)) u_dec (
    .instr_word (instr_word),
    .op_o       (op),
    .qsel_o     (qsel)
  );

  // state
  logic [NIRQ-1:0]   mask_q;
  logic [NIRQ-1:0]   mask_d;
  logic              mask_en;
  logic              halted_q;
  logic              halted_d;
  logic [NIRQ-1:0]   pend;
  logic [NIRQ-1:0]   fault_set;
  logic [DATA_W-1:0] q_rd;
  logic [DATA_W-1:0] mask_x;
  logic [DATA_W-1:0] pend_x;

  cxirq_pending #(.NIRQ(NIRQ)) u_pend (
    .clk       (clk),
    .rst_ni    (rst_ni),
    .irq_lines (irq_lines),
    .clr_i     (irq_clr),
    .set_i     (fault_set),
    .pending_o (pend)
  );

  cxirq_qbank #(.NQ(NQ), .DATA_W(DATA_W)) u_qbank (
    .clk       (clk),
    .rst_ni    (rst_ni),
    .save_en   (q_save_en),
    .save_idx  (q_save_idx),
    .save_data (q_save_data),
    .rd_idx    (qsel),
    .rd_data   (q_rd)
  );

  always_comb begin
    mask_x = '0;
    mask_x[NIRQ-1:0] = mask_q;
    pend_x = '0;
    pend_x[NIRQ-1:0] = pend;
  end

  // execute
  logic swap_fire;
  logic bad_fire;
  logic in_grp;

  assign in_grp = instr_valid && (op != CX_OP_NONE);

  always_comb begin
    instr_done = 1'b0;
    rd_val     = '0;
    swap_fire  = 1'b0;
    bad_fire   = 1'b0;
    if (instr_valid && !halted_q) begin
      case (op)
        CX_OP_SWAP: begin
          instr_done = 1'b1;
          rd_val     = mask_x;
          swap_fire  = 1'b1;
        end
        CX_OP_WAIT: begin
          if (|pend) begin
            instr_done = 1'b1;
            rd_val     = pend_x;
          end
        end
        CX_OP_GETQ: begin
          instr_done = 1'b1;
          rd_val     = q_rd;
        end
        CX_OP_BAD: begin
          instr_done = 1'b1;
          bad_fire   = 1'b1;
        end
        default: ;
      endcase
    end
  end

  assign instr_stall   = in_grp && !instr_done;
  assign illegal_pulse = bad_fire;

  // fault routing
  logic bus_evt;
  assign bus_evt = bus_err && !halted_q;

  always_comb begin
    fault_set          = '0;
    fault_set[ILL_BIT] = bad_fire && !mask_q[ILL_BIT];
    fault_set[BUS_BIT] = bus_evt && !mask_q[BUS_BIT];
    halted_d = halted_q
             | (bad_fire && mask_q[ILL_BIT])
             | (bus_evt && mask_q[BUS_BIT]);
  end

  // mask next state
  assign mask_en = swap_fire;
  assign mask_d  = rs1_val[NIRQ-1:0];

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '1;
    end else if (mask_en) begin
      mask_q <= mask_d;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) halted_q <= 1'b0;
    else         halted_q <= halted_d;
  end

  assign halted       = halted_q;
  assign irq_pending  = pend;
  assign irq_unmasked = pend & ~mask_q;

  // R2
  mask_swap_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (instr_done && op == CX_OP_SWAP) |=> (mask_q == $past(rs1_val[NIRQ-1:0])));

  // R9
  halt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    halted |=> halted);

  // R9
  halt_nodone_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    halted |-> !instr_done);

  // R11
  done_stall_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    !(instr_done && instr_stall));

  // R5
  wait_pend_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (instr_done && op == CX_OP_WAIT) |-> (|irq_pending));

  // R8
  bus_halt_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (bus_err && !halted && mask_q[BUS_BIT]) |=> halted);

endmodule

// File: tb/cxirq_unit_tb.sv
module cxirq_unit_tb;

  localparam int NIRQ = 32;
  localparam int DW   = 32;

  logic            clk;
  logic            rst_n;
  logic            instr_valid;
  logic [31:0]     instr_word;
  logic [DW-1:0]   rs1_val;
  logic [NIRQ-1:0] irq_lines;
  logic [NIRQ-1:0] irq_clr;
  logic            bus_err;
  logic            q_save_en;
  logic [1:0]      q_save_idx;
  logic [DW-1:0]   q_save_data;
  logic [DW-1:0]   rd_val;
  logic            instr_done;
  logic            instr_stall;
  logic            illegal_pulse;
  logic            halted;
  logic [NIRQ-1:0] irq_pending;
  logic [NIRQ-1:0] irq_unmasked;

  int n_tests = 0;
  int n_fail  = 0;

  cxirq_unit u_dut (
    .clk           (clk),
    .rst_n         (rst_n),
    .instr_valid   (instr_valid),
    .instr_word    (instr_word),
    .rs1_val       (rs1_val),
    .irq_lines     (irq_lines),
    .irq_clr       (irq_clr),
    .bus_err       (bus_err),
    .q_save_en     (q_save_en),
    .q_save_idx    (q_save_idx),
    .q_save_data   (q_save_data),
    .rd_val        (rd_val),
    .instr_done    (instr_done),
    .instr_stall   (instr_stall),
    .illegal_pulse (illegal_pulse),
    .halted        (halted),
    .irq_pending   (irq_pending),
    .irq_unmasked  (irq_unmasked)
  );

  initial clk = 1'b0;
  always #2ns clk = ~clk;

  function automatic logic [31:0] enc(input logic [6:0] f7, input logic [4:0] rs1f,
                                      input logic [2:0] f3 = 3'b000,
                                      input logic [4:0] rs2f = 5'd0,
                                      input logic [6:0] opc = 7'b0001011);
    return {f7, rs2f, rs1f, f3, 5'd10, opc};
  endfunction

  localparam logic [6:0] F_SWAP = 7'b0000011;
  localparam logic [6:0] F_WAIT = 7'b0000100;
  localparam logic [6:0] F_GETQ = 7'b0000000;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive_instr(input logic [31:0] w, input logic [31:0] r);
    @(negedge clk);
    instr_valid = 1'b1;
    instr_word  = w;
    rs1_val     = r;
    #1ns;
  endtask

  task automatic idle();
    @(negedge clk);
    instr_valid = 1'b0;
    instr_word  = '0;
    rs1_val     = '0;
    #1ns;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    instr_valid = 1'b0; instr_word = '0; rs1_val = '0;
    irq_lines = '0; irq_clr = '0; bus_err = 1'b0;
    q_save_en = 1'b0; q_save_idx = '0; q_save_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1ns;
  endtask

  task automatic set_mask(input logic [31:0] m);
    drive_instr(enc(F_SWAP, 5'd11), m);
    idle();
  endtask

  task automatic clear_all();
    @(negedge clk);
    irq_clr = '1;
    @(negedge clk);
    irq_clr = '0;
    #1ns;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R10 halted after reset", {31'd0, halted}, 32'd0);
    chk("R10 pending after reset", irq_pending, 32'd0);
    chk("R11 done idle", {31'd0, instr_done}, 32'd0);
    drive_instr(enc(F_SWAP, 5'd11), 32'h0);
    chk("R10 reset mask all ones", rd_val, 32'hFFFF_FFFF);
    chk("R2 swap done", {31'd0, instr_done}, 32'd1);
    chk("R11 swap no stall", {31'd0, instr_stall}, 32'd0);
    idle();
    chk("R11 rd zero without done", rd_val, 32'd0);
  endtask

  task automatic t_swap();
    drive_instr(enc(F_SWAP, 5'd11), 32'hA5A5_0000);
    chk("R2 old mask returned", rd_val, 32'h0);
    idle();
    drive_instr(enc(F_SWAP, 5'd11), 32'h0000_0000);
    chk("R2 new mask visible", rd_val, 32'hA5A5_0000);
    idle();
  endtask

  task automatic t_pending();
    set_mask(32'h0000_0080);
    @(negedge clk); irq_lines[5] = 1'b1; irq_lines[7] = 1'b1; #1ns;
    chk("R4 not yet pending", irq_pending, 32'h0);
    @(negedge clk); #1ns;
    chk("R4 pending after rise", irq_pending, 32'h0000_00A0);
    chk("R3 unmasked view", irq_unmasked, 32'h0000_0020);
    @(negedge clk); irq_lines = '0; #1ns;
    @(negedge clk); #1ns;
    chk("R4 held after line drops", irq_pending, 32'h0000_00A0);
    @(negedge clk); irq_clr[5] = 1'b1; #1ns;
    @(negedge clk); irq_clr = '0; #1ns;
    chk("R4 clear one bit", irq_pending, 32'h0000_0080);
    @(negedge clk); irq_clr[7] = 1'b1; irq_lines[7] = 1'b1; #1ns;
    @(negedge clk); irq_clr = '0; irq_lines = '0; #1ns;
    chk("R4 rise wins over clear", irq_pending, 32'h0000_0080);
    clear_all();
    chk("R4 cleared", irq_pending, 32'h0);
  endtask

  task automatic t_wait();
    set_mask(32'hFFFF_FFFF);
    drive_instr(enc(F_WAIT, 5'd0), 32'h0);
    chk("R5 stall while idle", {31'd0, instr_stall}, 32'd1);
    chk("R5 no done while idle", {31'd0, instr_done}, 32'd0);
    @(negedge clk); irq_lines[9] = 1'b1; #1ns;
    chk("R5 still stalled", {31'd0, instr_stall}, 32'd1);
    @(negedge clk); #1ns;
    chk("R5 done on masked pending", {31'd0, instr_done}, 32'd1);
    chk("R5 returns pending set", rd_val, 32'h0000_0200);
    idle();
    irq_lines = '0;
    clear_all();
    drive_instr(enc(F_WAIT, 5'd3), 32'h0);
    chk("R7 wait with rs1 field nonzero illegal", {30'd0, illegal_pulse, instr_done}, 32'd3);
    idle();
    chk("R7 illegal pulse one cycle", {31'd0, illegal_pulse}, 32'd0);
    chk("R8 masked illegal halts", {31'd0, halted}, 32'd1);
  endtask

  task automatic t_getq();
    @(negedge clk);
    q_save_en = 1'b1; q_save_idx = 2'd2; q_save_data = 32'h0000_1234;
    @(negedge clk);
    q_save_idx = 2'd3; q_save_data = 32'hDEAD_BEEF;
    @(negedge clk);
    q_save_en = 1'b0;
    drive_instr(enc(F_GETQ, 5'd2), 32'h0);
    chk("R6 read q2", rd_val, 32'h0000_1234);
    idle();
    drive_instr(enc(F_GETQ, 5'd3), 32'h0);
    chk("R6 read q3", rd_val, 32'hDEAD_BEEF);
    idle();
    drive_instr(enc(F_GETQ, 5'd0), 32'h0);
    chk("R6 read q0 reset", rd_val, 32'h0);
    idle();
  endtask

  task automatic t_outgroup();
    set_mask(32'h0000_00F0);
    drive_instr(enc(F_SWAP, 5'd11, 3'b000, 5'd0, 7'b0110011), 32'h1);
    chk("R1 other opcode ignored", {29'd0, instr_done, instr_stall, illegal_pulse}, 32'd0);
    idle();
    drive_instr(enc(F_SWAP, 5'd11, 3'b001), 32'h1);
    chk("R1 nonzero funct3 ignored", {29'd0, instr_done, instr_stall, illegal_pulse}, 32'd0);
    idle();
    drive_instr(enc(F_SWAP, 5'd11, 3'b000, 5'd4), 32'h1);
    chk("R1 nonzero rs2 ignored", {29'd0, instr_done, instr_stall, illegal_pulse}, 32'd0);
    idle();
    drive_instr(enc(F_SWAP, 5'd11), 32'h0);
    chk("R1 mask unchanged", rd_val, 32'h0000_00F0);
    idle();
  endtask

  task automatic t_fault_unmasked();
    clear_all();
    drive_instr(enc(7'b0000111, 5'd0), 32'h0);
    chk("R7 illegal completes", {30'd0, illegal_pulse, instr_done}, 32'd3);
    chk("R7 illegal rd zero", rd_val, 32'h0);
    idle();
    chk("R8 illegal sets bit 1", irq_pending, 32'h0000_0002);
    chk("R8 no halt unmasked", {31'd0, halted}, 32'd0);
    drive_instr(enc(F_GETQ, 5'd9), 32'h0);
    chk("R7 getq high rs1 bits illegal", {31'd0, illegal_pulse}, 32'd1);
    idle();
    @(negedge clk); bus_err = 1'b1;
    @(negedge clk); bus_err = 1'b0; #1ns;
    chk("R8 bus error sets bit 2", irq_pending, 32'h0000_0006);
    chk("R8 bus error no halt", {31'd0, halted}, 32'd0);
    clear_all();
  endtask

  task automatic t_halt_bus();
    do_reset();
    chk("R10 halt cleared by reset", {31'd0, halted}, 32'd0);
    @(negedge clk); bus_err = 1'b1;
    @(negedge clk); bus_err = 1'b0; #1ns;
    chk("R8 masked bus error halts", {31'd0, halted}, 32'd1);
    chk("R8 masked fault not pending", irq_pending, 32'h0);
    drive_instr(enc(F_SWAP, 5'd11), 32'h0);
    chk("R9 no done while halted", {31'd0, instr_done}, 32'd0);
    chk("R9 stall while halted", {31'd0, instr_stall}, 32'd1);
    idle();
    repeat (5) @(negedge clk);
    #1ns;
    chk("R9 halt sticky", {31'd0, halted}, 32'd1);
  endtask

  task automatic run_all();
    t_reset();
    t_swap();
    t_pending();
    t_getq();
    t_outgroup();
    t_fault_unmasked();
    t_wait();
    t_halt_bus();
  endtask

  initial begin
    rst_n = 1'b0;
    instr_valid = 1'b0; instr_word = '0; rs1_val = '0;
    irq_lines = '0; irq_clr = '0; bus_err = 1'b0;
    q_save_en = 1'b0; q_save_idx = '0; q_save_data = '0;
    fork
      run_all();
      begin
        repeat (100000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule